// File: doc/BRIEF.md
# Priority Crossbar Pin Allocator

This block decides which peripheral signal appears on each of 32 port pins, arranged as four ports of eight bits. Eight peripheral functions are considered in a fixed priority order. The two highest-priority functions, a UART and a CAN controller, are tied to fixed pins. Every other enabled function is placed on the lowest-numbered pins still free. A pin counts as taken when its skip bit is set, when its analog flag is set, when a fixed function holds it, or when a higher-priority signal has already claimed it. Software uses the skip bits to keep pins back for analog inputs, dedicated circuits or plain GPIO.

The allocation is computed combinationally from the enables, skip masks and analog flags. The resulting pin map and the per-function placed flags are registered on the next clock edge. Output drivers, pads and the peripherals themselves lie outside this block.

Top module: `pin_crossbar`

## Requirements
- R1: When `func_en[0]` (UART) is set, pin 4 carries signal 0 and pin 5 carries signal 1, both valid, whatever the skip and analog bits of those pins say.
- R2: When `func_en[1]` (CAN) is set, pin 6 carries signal 2 and pin 7 carries signal 3, both valid, whatever the skip and analog bits of those pins say.
- R3: Signal indices are numbered as follows: SPI 4–7, I2C 8–9, comparator output 10, PWM 11–16, clock output 17, timer inputs 18–19. Functions 2 to 7 are placed in that order, and each function's signals are placed in index order. Every signal takes the lowest-numbered free pin, where pin index = port*8 + bit. No signal appears on more than one pin.
- R4: A pin whose skip bit (`skip_mask[port*8+bit]`) is set is never given to a signal of functions 2 to 7.
- R5: A pin whose analog flag is set is never given to a signal of functions 2 to 7.
- R6: A disabled function takes no pins, and its placed flag reads 0. The fixed pins of a disabled UART or CAN are free for the walk.
- R7: When the free pins run out, the signals that still fit take the remaining pins. The function left incomplete and every later enabled function read placed = 0.
- R8: `func_placed[f]` is 1 exactly when function f is enabled and every one of its signals sits on a pin.
- R9: Outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low at an edge, all outputs are cleared to 0.
- R10: A pin that carries no signal has `pin_valid` = 0 and a signal index of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| func_en | input | 8 | Function enables, bit f = function f (priority order) |
| skip_mask | input | 32 | Skip bits of the four ports, bit port*8+bit |
| analog_mode | input | 32 | Per-pin analog-mode flags |
| pin_sig | output | 160 | Per-pin signal index, 5 bits per pin, pin j at bits j*5 +: 5 |
| pin_valid | output | 32 | Per-pin "signal assigned" flag |
| func_placed | output | 8 | Per-function "all signals placed" flag |

## Verification
The hardest case to reach is exhaustion part-way through a multi-signal function, while fixed pins are also skipped or analog. Here the incomplete function keeps its partial pins and everything after it goes unplaced. The stimulus reaches this case with skip and analog masks that leave only one to twelve free pins, next to an enabled UART and CAN. It also runs a long stream of random enable, sparse skip and analog patterns. Every pin and flag is compared against a sequential greedy walk written separately in the bench.

// File: rtl/xbar_pkg.sv
// Shared sizes and the function/signal table of the pin allocator.
// Assumes the fixed-pin functions occupy the lowest function and signal
// indices, and that their pins form one contiguous window.
package xbar_pkg;
    localparam int PORT_W       = 8;
    localparam int NUM_PORTS    = 4;
    localparam int NUM_PINS     = PORT_W * NUM_PORTS;
    localparam int NUM_FUNCS    = 8;
    localparam int NUM_SIGS     = 20;
    localparam int SIG_W        = $clog2(NUM_SIGS);
    localparam int CNT_W        = $clog2(NUM_PINS + 1);
    localparam int FIX_FUNCS    = 2;
    localparam int FIX_SIGS     = 4;
    localparam int FIX_PIN_BASE = 4;

    // Number of signals belonging to function f.
    function automatic int func_size(input int f);
        case (f)
            0: return 2;
            1: return 2;
            2: return 4;
            3: return 2;
            4: return 1;
            5: return 6;
            6: return 1;
            default: return 2;
        endcase
    endfunction

    // Index of the first signal of function f.
    function automatic int func_first(input int f);
        int acc = 0;
        for (int k = 0; k < f; k++) acc += func_size(k);
        return acc;
    endfunction

    // Function that owns signal s.
    function automatic int sig_owner(input int s);
        int owner = 0;
        for (int k = 0; k < NUM_FUNCS; k++)
            if (s >= func_first(k)) owner = k;
        return owner;
    endfunction
endpackage

// File: rtl/xbar_free_mask.sv
// Builds the set of pins open to the priority walk, and the fixed-pin
// assignments. A pin in the fixed window is held by its fixed signal when
// the owning function is enabled, regardless of skip or analog settings.
// Any pin that is skipped, analog or fixed-held is closed to the walk.
module xbar_free_mask
    import xbar_pkg::*;
(
    input  logic [NUM_FUNCS-1:0]            func_en,
    input  logic [NUM_PINS-1:0]             skip_mask,
    input  logic [NUM_PINS-1:0]             analog_mode,
    output logic [NUM_PINS-1:0]             free_pin,
    output logic [NUM_PINS-1:0]             fixed_valid,
    output logic [NUM_PINS-1:0][SIG_W-1:0]  fixed_sig
);
    for (genvar j = 0; j < NUM_PINS; j++) begin : g_pin
        if (j >= FIX_PIN_BASE && j < FIX_PIN_BASE + FIX_SIGS) begin : g_fix
            localparam int S = j - FIX_PIN_BASE;
            // Fixed pin: claimed whenever its owning function is on.
            assign fixed_valid[j] = func_en[sig_owner(S)];
            assign fixed_sig[j]   = SIG_W'(S);
        end else begin : g_open
            // Ordinary pin: never fixed-held.
            assign fixed_valid[j] = 1'b0;
            assign fixed_sig[j]   = '0;
        end
        // A pin is open to the walk only if nothing reserves it.
        assign free_pin[j] = !(skip_mask[j] | analog_mode[j] | fixed_valid[j]);
    end
endmodule

// File: rtl/xbar_rank.sv
// Gives each enabled movable signal its rank: the number of enabled
// movable signals ahead of it in priority order. Rank k means "takes the
// k-th free pin". Fixed signals are never ranked.
module xbar_rank
    import xbar_pkg::*;
(
    input  logic [NUM_FUNCS-1:0]            func_en,
    output logic [NUM_SIGS-1:0]             sig_en,
    output logic [NUM_SIGS-1:0][CNT_W-1:0]  sig_rank
);
    logic [CNT_W-1:0] acc;

    // Prefix count of enabled movable signals in priority order.
    always_comb begin
        acc = '0;
        for (int s = 0; s < NUM_SIGS; s++) begin
            sig_en[s]   = (s >= FIX_SIGS) && func_en[sig_owner(s)];
            sig_rank[s] = acc;
            if (sig_en[s]) acc = acc + CNT_W'(1);
        end
    end
endmodule

// File: rtl/xbar_pin_match.sv
// Matches ranked signals to free pins. The k-th free pin (counting from
// pin 0 upward) receives the movable signal of rank k. This equals a
// greedy lowest-free-pin walk without a serial chain across the pins.
module xbar_pin_match
    import xbar_pkg::*;
(
    input  logic [NUM_PINS-1:0]             free_pin,
    input  logic [NUM_SIGS-1:0]             sig_en,
    input  logic [NUM_SIGS-1:0][CNT_W-1:0]  sig_rank,
    output logic [NUM_PINS-1:0]             move_valid,
    output logic [NUM_PINS-1:0][SIG_W-1:0]  move_sig,
    output logic [NUM_SIGS-1:0]             sig_placed
);
    logic [NUM_PINS-1:0][CNT_W-1:0] free_rank;
    logic [CNT_W-1:0]               free_total;
    logic [CNT_W-1:0]               acc;

    // Prefix count of free pins below each pin, and the total.
    always_comb begin
        acc = '0;
        for (int j = 0; j < NUM_PINS; j++) begin
            free_rank[j] = acc;
            if (free_pin[j]) acc = acc + CNT_W'(1);
        end
        free_total = acc;
    end

    for (genvar j = 0; j < NUM_PINS; j++) begin : g_pin
        logic             hit;
        logic [SIG_W-1:0] hit_sig;

        // Find the signal whose rank equals this free pin's rank.
        always_comb begin
            hit     = 1'b0;
            hit_sig = '0;
            for (int s = 0; s < NUM_SIGS; s++) begin
                if (free_pin[j] && sig_en[s] && sig_rank[s] == free_rank[j]) begin
                    hit     = 1'b1;
                    hit_sig = SIG_W'(s);
                end
            end
        end

        assign move_valid[j] = hit;
        assign move_sig[j]   = hit_sig;
    end

    // A signal lands on a pin when its rank is below the free-pin count.
    always_comb begin
        for (int s = 0; s < NUM_SIGS; s++)
            sig_placed[s] = sig_en[s] && (sig_rank[s] < free_total);
    end
endmodule

// File: rtl/pin_crossbar.sv
// Priority crossbar pin allocator, top level. It merges the fixed-pin and
// walked assignments, derives per-function placed flags and registers
// everything. Synchronous active-low reset clears all outputs. Inputs are
// assumed to be synchronous to clk.
module pin_crossbar
    import xbar_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_FUNCS-1:0]        func_en,
    input  logic [NUM_PINS-1:0]         skip_mask,
    input  logic [NUM_PINS-1:0]         analog_mode,
    output logic [NUM_PINS*SIG_W-1:0]   pin_sig,
    output logic [NUM_PINS-1:0]         pin_valid,
    output logic [NUM_FUNCS-1:0]        func_placed
);
    logic [NUM_PINS-1:0]             free_pin;
    logic [NUM_PINS-1:0]             fixed_valid;
    logic [NUM_PINS-1:0][SIG_W-1:0]  fixed_sig;
    logic [NUM_SIGS-1:0]             sig_en;
    logic [NUM_SIGS-1:0][CNT_W-1:0]  sig_rank;
    logic [NUM_PINS-1:0]             move_valid;
    logic [NUM_PINS-1:0][SIG_W-1:0]  move_sig;
    logic [NUM_SIGS-1:0]             sig_placed;

    logic [NUM_PINS-1:0]             nxt_valid;
    logic [NUM_PINS-1:0][SIG_W-1:0]  nxt_sig;
    logic [NUM_FUNCS-1:0]            nxt_placed;
    logic [NUM_PINS-1:0][SIG_W-1:0]  sig_q;

    xbar_free_mask u_free (
        .func_en     (func_en),
        .skip_mask   (skip_mask),
        .analog_mode (analog_mode),
        .free_pin    (free_pin),
        .fixed_valid (fixed_valid),
        .fixed_sig   (fixed_sig)
    );

    xbar_rank u_rank (
        .func_en  (func_en),
        .sig_en   (sig_en),
        .sig_rank (sig_rank)
    );

    xbar_pin_match u_match (
        .free_pin   (free_pin),
        .sig_en     (sig_en),
        .sig_rank   (sig_rank),
        .move_valid (move_valid),
        .move_sig   (move_sig),
        .sig_placed (sig_placed)
    );

    // Merge fixed and walked assignments; walked pins never overlap fixed ones.
    always_comb begin
        for (int j = 0; j < NUM_PINS; j++) begin
            nxt_valid[j] = fixed_valid[j] | move_valid[j];
            nxt_sig[j]   = fixed_valid[j] ? fixed_sig[j] :
                           move_valid[j]  ? move_sig[j]  : '0;
        end
    end

    // Per-function placed flag: fixed functions always fit; others need their last signal placed.
    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_func
        if (f < FIX_FUNCS) begin : g_fixed
            assign nxt_placed[f] = func_en[f];
        end else begin : g_walk
            localparam int LAST = func_first(f) + func_size(f) - 1;
            assign nxt_placed[f] = func_en[f] && sig_placed[LAST];
        end
    end

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_valid   <= '0;
            sig_q       <= '0;
            func_placed <= '0;
        end else begin
            pin_valid   <= nxt_valid;
            sig_q       <= nxt_sig;
            func_placed <= nxt_placed;
        end
    end

    assign pin_sig = sig_q;

    // ---------------- assertions ----------------

    // R1
    uart_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        func_en[0] |=> pin_valid[FIX_PIN_BASE] && sig_q[FIX_PIN_BASE] == SIG_W'(0)
                    && pin_valid[FIX_PIN_BASE+1] && sig_q[FIX_PIN_BASE+1] == SIG_W'(1));

    // R2
    can_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        func_en[1] |=> pin_valid[FIX_PIN_BASE+2] && sig_q[FIX_PIN_BASE+2] == SIG_W'(2)
                    && pin_valid[FIX_PIN_BASE+3] && sig_q[FIX_PIN_BASE+3] == SIG_W'(3));

    for (genvar j = 0; j < NUM_PINS; j++) begin : g_pin_chk
        if (j >= FIX_PIN_BASE && j < FIX_PIN_BASE + FIX_SIGS) begin : g_fx
            // R4 R5
            reserved_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((skip_mask[j] | analog_mode[j]) && !func_en[sig_owner(j - FIX_PIN_BASE)])
                |=> !pin_valid[j]);
        end else begin : g_op
            // R4 R5
            reserved_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (skip_mask[j] | analog_mode[j]) |=> !pin_valid[j]);
        end
        // R10
        idle_sig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_valid[j] |-> sig_q[j] == '0);
    end

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_func_chk
        // R6
        disabled_unplaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !func_en[f] |=> !func_placed[f]);
    end

    for (genvar s = 0; s < NUM_SIGS; s++) begin : g_sig_chk
        logic [NUM_PINS-1:0] on_pin;
        // Which registered pins carry signal s.
        always_comb begin
            for (int j = 0; j < NUM_PINS; j++)
                on_pin[j] = pin_valid[j] && sig_q[j] == SIG_W'(s);
        end
        // R3
        single_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(on_pin) <= 1);
    end
endmodule

// File: tb/test_pin_crossbar.sv
module test_pin_crossbar;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;
    localparam int NF = 8;
    localparam int SW = 5;
    localparam int FSZ [NF] = '{2, 2, 4, 2, 1, 6, 1, 2};
    localparam int NVEC = 8;
    // {enables, skip, analog, expected placed flags}
    localparam logic [79:0] VECS [NVEC] = '{
        {8'hFF, 32'h0000_0000, 32'h0000_0000, 8'hFF},
        {8'h04, 32'h0000_0000, 32'h0000_0000, 8'h04},
        {8'hFF, 32'hFFFF_FFF0, 32'h0000_0000, 8'h07},
        {8'h00, 32'hFFFF_FFFF, 32'h0000_0000, 8'h00},
        {8'hFF, 32'h0000_0000, 32'h7FFF_FFFF, 8'h03},
        {8'h12, 32'h0000_0000, 32'h0000_0000, 8'h12},
        {8'h10, 32'h0000_000F, 32'h0000_0000, 8'h10},
        {8'hFF, 32'h0F0F_0F0F, 32'h0000_0000, 8'h1F}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NF-1:0]   func_en;
    logic [NP-1:0]   skip_mask;
    logic [NP-1:0]   analog_mode;
    logic [NP*SW-1:0] pin_sig;
    logic [NP-1:0]   pin_valid;
    logic [NF-1:0]   func_placed;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [NP-1:0]    r_valid;
    logic [NP*SW-1:0] r_sig;
    logic [NF-1:0]    r_placed;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_crossbar i_pin_crossbar (
        .clk         (clk),
        .rst_n       (rst_n),
        .func_en     (func_en),
        .skip_mask   (skip_mask),
        .analog_mode (analog_mode),
        .pin_sig     (pin_sig),
        .pin_valid   (pin_valid),
        .func_placed (func_placed)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sequential greedy reference walk built from the requirements.
    task automatic ref_walk(input logic [NF-1:0] en, input logic [NP-1:0] sk,
                            input logic [NP-1:0] an);
        logic [NP-1:0] occ;
        int base;
        r_valid = '0; r_sig = '0; r_placed = '0;
        occ = sk | an;
        for (int f = 0; f < 2; f++) begin
            if (en[f]) begin
                for (int k = 0; k < 2; k++) begin
                    r_valid[4 + 2*f + k] = 1'b1;
                    r_sig[(4 + 2*f + k)*SW +: SW] = SW'(2*f + k);
                end
                r_placed[f] = 1'b1;
            end
        end
        occ = occ | r_valid;
        base = 4;
        for (int f = 2; f < NF; f++) begin
            if (en[f]) begin
                bit ok = 1'b1;
                for (int k = 0; k < FSZ[f]; k++) begin
                    bit found = 1'b0;
                    for (int p = 0; p < NP; p++) begin
                        if (!found && !occ[p]) begin
                            found = 1'b1;
                            occ[p] = 1'b1;
                            r_valid[p] = 1'b1;
                            r_sig[p*SW +: SW] = SW'(base + k);
                        end
                    end
                    if (!found) ok = 1'b0;
                end
                r_placed[f] = ok;
            end
            base += FSZ[f];
        end
    endtask

    task automatic apply(input logic [NF-1:0] en, input logic [NP-1:0] sk,
                         input logic [NP-1:0] an);
        @(negedge clk);
        func_en = en; skip_mask = sk; analog_mode = an;
        @(negedge clk);
        ref_walk(en, sk, an);
    endtask

    task automatic compare_all(input string tag);
        check({tag, " R3 R4 R5 R6 pin_valid"}, 256'(pin_valid), 256'(r_valid));
        check({tag, " R3 R10 pin_sig"}, 256'(pin_sig), 256'(r_sig));
        check({tag, " R7 R8 func_placed"}, 256'(func_placed), 256'(r_placed));
    endtask

    initial begin
        rst_n = 1'b0;
        func_en = '1; skip_mask = '0; analog_mode = '0;
        repeat (3) @(negedge clk);
        // R9: reset clears every output
        check("R9 reset pin_valid", 256'(pin_valid), 256'(0));
        check("R9 reset pin_sig", 256'(pin_sig), 256'(0));
        check("R9 reset func_placed", 256'(func_placed), 256'(0));
        rst_n = 1'b1;
        func_en = '0;
        @(negedge clk);
        @(negedge clk);

        // Table of vectors
        for (int v = 0; v < NVEC; v++) begin
            apply(VECS[v][79:72], VECS[v][71:40], VECS[v][39:8]);
            compare_all("vector");
            check("R8 table placed", 256'(func_placed), 256'(VECS[v][7:0]));
            if (v == 4) begin
                // R7: partial SPI on the one free pin 31
                check("R7 partial pin31 valid", 256'(pin_valid[31]), 256'(1));
                check("R7 partial pin31 sig", 256'(pin_sig[31*SW +: SW]), 256'(4));
            end
            if (v == 6) begin
                // R6: disabled UART frees pin 4 for the comparator output
                check("R6 freed pin4 sig", 256'(pin_sig[4*SW +: SW]), 256'(10));
                check("R6 freed pin4 valid", 256'(pin_valid[4]), 256'(1));
            end
        end

        // R1 R2: fixed pins placed though every pin is skipped and analog
        apply(8'h03, '1, '1);
        check("R1 uart pin4", 256'({pin_valid[4], pin_sig[4*SW +: SW]}), 256'({1'b1, 5'd0}));
        check("R1 uart pin5", 256'({pin_valid[5], pin_sig[5*SW +: SW]}), 256'({1'b1, 5'd1}));
        check("R2 can pin6", 256'({pin_valid[6], pin_sig[6*SW +: SW]}), 256'({1'b1, 5'd2}));
        check("R2 can pin7", 256'({pin_valid[7], pin_sig[7*SW +: SW]}), 256'({1'b1, 5'd3}));
        check("R4 R5 others empty", 256'(pin_valid & ~32'h0000_00F0), 256'(0));

        // R9: one-edge latency
        apply(8'h00, '0, '0);
        @(negedge clk);
        func_en = 8'h10;
        #1;
        check("R9 before edge", 256'(pin_valid), 256'(0));
        @(negedge clk);
        check("R9 after edge pin0", 256'({pin_valid[0], pin_sig[0 +: SW]}), 256'({1'b1, 5'd10}));

        // Random patterns against the reference walk
        for (int n = 0; n < 400; n++) begin
            apply(NF'($urandom), $urandom & $urandom, $urandom & $urandom & $urandom);
            compare_all("random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule